// File: doc/BRIEF.md
# Addend-Compensated PTP Time-of-Day Timer

This block keeps a 64-bit nanosecond time-of-day count for precision time protocol timestamping. It runs on a single core clock. One of four reference strobes, chosen by a clock-select register, marks each reference period. On every selected strobe a 32-bit addend is summed into a 32-bit phase accumulator. Each carry out of that accumulator is one nominal tick, and each tick advances the time counter by a programmed nominal period in nanoseconds. Trimming the addend therefore trims the frequency finely. The addend normally equals ceil(2^32 / R), where R is the reference rate over the nominal tick rate, and R must exceed 1.

A prescaler divides the tick stream into a square output clock. Two fixed-interval pulse generators each time their own interval in nanoseconds, for example to produce one pulse per second. Each generator reloads itself when it fires, so no error builds up over time. Each firing also sets a sticky interrupt flag. An enable mask gates these flags onto the interrupt pins.

Software drives the block through a plain write-only port made of an enable, an address and 32 bits of data. The block carries no data stream, so it has no valid/ready handshake.

Top module: `ptp_tod_core`

## Requirements
- R1: After reset, the time is 0. All pulse and interrupt outputs are 0. Counting is disabled. The clock-select field holds 1, which selects `ref_tick_i[1]`.
- R2: With counting enabled, every selected strobe adds the addend (address 1) into the 32-bit accumulator. A carry out makes one tick, and the tick adds the nominal period (address 2) to the time. At most one tick occurs per strobe.
- R3: A new addend is used from the next strobe on. The accumulator is not cleared, so its residue carries over.
- R4: The clock-select field (address 10, bits [1:0]) selects which bit of `ref_tick_i` counts: 0 external, 1 system, 2 transmit, 3 real-time. Strobes on the other bits have no effect on the time.
- R5: Bit 0 of the control register (address 0) enables counting. While it is 0, strobes do not move the time.
- R6: A write to address 4 stages the low 32 time bits. A write to address 5 loads {data, staged low} into the time. The load wins over a tick in the same cycle. The load also restarts both pulse generators and drops their outputs.
- R7: The time wraps modulo 2^64.
- R8: Generator i (interval register at address 6+i) fires on the tick at which the nanoseconds since its last firing (or since the last load) reach the stored value plus one nominal period. Firing never drifts.
- R9: A pulse output rises on firing and stays high for P ticks, where P is the prescaler value (address 3).
- R10: The output clock is high while the prescaler tick count is below P/2 and low for the rest of each P-tick cycle (P ≥ 2).
- R11: Firing of generator i sets status flag i. Writing 1 to bit i at address 8 clears the flag, writing 0 leaves it alone, and a firing in the same cycle wins.
- R12: `irq_o[i]` equals flag i ANDed with mask bit i (address 9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low reset |
| ref_tick_i | input | 4 | reference strobes, one per source |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | 4 | register address |
| wr_data_i | input | 32 | register write data |
| tod_o | output | 64 | time of day in ns |
| outclk_o | output | 1 | prescaled output clock |
| pulse_o | output | 2 | fixed-interval pulses |
| irq_o | output | 2 | masked interrupt outputs |

## Verification
The bench changes the addend after an odd number of strobes. A design that clears the accumulator on that write would lose the tick that the leftover residue should produce. It reloads the time right after the fixed-interval registers are set, and checks that the first pulses land exactly one interval after the load. A generator that did not restart, or that counted one tick too many or too few, would put those pulses at the wrong time. It also loads a value close to 2^64 to test wrap-around. It checks that writing 0 to the status register keeps a flag set, and that a strobe on an unselected source leaves the time unchanged.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int A_CTRL   = 0;
  localparam int A_ADDEND = 1;
  localparam int A_NOMPER = 2;
  localparam int A_PRESC  = 3;
  localparam int A_TODLO  = 4;
  localparam int A_TODHI  = 5;
  localparam int A_FIPER0 = 6;
  localparam int A_STAT   = 8;
  localparam int A_IMASK  = 9;
  localparam int A_CLKSEL = 10;

  typedef enum logic [1:0] {
    REF_EXT = 2'd0,
    REF_SYS = 2'd1,
    REF_TX  = 2'd2,
    REF_RTC = 2'd3
  } ref_sel_e;
endpackage

// File: rtl/ptp_phase_acc.sv
module ptp_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic [ACC_W-1:0] addend_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, addend_i};
  assign tick_o = step_i & sum[ACC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (step_i) acc_q <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/ptp_prescaler.sv
module ptp_prescaler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [W-1:0] div_i,
  output logic         outclk_o
);
  logic [W-1:0] cnt_q;
  logic         last;

  assign last     = (div_i <= W'(1)) || (cnt_q >= div_i - W'(1));
  assign outclk_o = (cnt_q < (div_i >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_i) cnt_q <= last ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/ptp_fiper.sv
module ptp_fiper #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] interval_i,
  input  logic [W-1:0] width_i,
  output logic         fire_o,
  output logic         pulse_o
);
  logic [W-1:0] el_q;
  logic [W-1:0] wcnt_q;

  assign fire_o  = tick_i && !clr_i && (el_q >= interval_i);
  assign pulse_o = (wcnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      el_q   <= '0;
      wcnt_q <= '0;
    end else if (clr_i) begin
      el_q   <= '0;
      wcnt_q <= '0;
    end else if (tick_i) begin
      if (fire_o) begin
        el_q   <= el_q - interval_i;
        wcnt_q <= width_i;
      end else begin
        el_q <= el_q + period_i;
        if (wcnt_q != '0) wcnt_q <= wcnt_q - W'(1);
      end
    end
  end
endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core
  import ptp_tod_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ACC_W     = 32,
  parameter int TOD_W     = 64,
  parameter int NUM_FIPER = 2,
  parameter int NUM_REF   = 4,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_REF-1:0]   ref_tick_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic [TOD_W-1:0]     tod_o,
  output logic                 outclk_o,
  output logic [NUM_FIPER-1:0] pulse_o,
  output logic [NUM_FIPER-1:0] irq_o
);
  localparam int SEL_W = $clog2(NUM_REF);

  logic                 en_q;
  logic [SEL_W-1:0]     sel_q;
  logic [ACC_W-1:0]     addend_q;
  logic [DATA_W-1:0]    nomper_q;
  logic [DATA_W-1:0]    presc_q;
  logic [DATA_W-1:0]    todlo_q;
  logic [NUM_FIPER-1:0] imask_q;
  logic [NUM_FIPER-1:0] flag_q;
  logic [TOD_W-1:0]     tod_q;
  logic [DATA_W-1:0]    fiper_q [NUM_FIPER];

  logic                 step;
  logic                 tick;
  logic                 tod_load;
  logic [NUM_FIPER-1:0] fire;
  logic [NUM_FIPER-1:0] stat_clr;

  function automatic logic hit(input int a);
    return wr_en_i && (wr_addr_i == ADDR_W'(a));
  endfunction

  assign step     = en_q & ref_tick_i[sel_q];
  assign tod_load = hit(A_TODHI);
  assign stat_clr = hit(A_STAT) ? wr_data_i[NUM_FIPER-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      sel_q    <= SEL_W'(REF_SYS);
      addend_q <= '0;
      nomper_q <= '0;
      presc_q  <= '0;
      todlo_q  <= '0;
      imask_q  <= '0;
    end else begin
      if (hit(A_CTRL))   en_q     <= wr_data_i[0];
      if (hit(A_CLKSEL)) sel_q    <= wr_data_i[SEL_W-1:0];
      if (hit(A_ADDEND)) addend_q <= ACC_W'(wr_data_i);
      if (hit(A_NOMPER)) nomper_q <= wr_data_i;
      if (hit(A_PRESC))  presc_q  <= wr_data_i;
      if (hit(A_TODLO))  todlo_q  <= wr_data_i;
      if (hit(A_IMASK))  imask_q  <= wr_data_i[NUM_FIPER-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tod_q <= '0;
    else if (tod_load) tod_q <= TOD_W'({wr_data_i, todlo_q});
    else if (tick)     tod_q <= tod_q + TOD_W'(nomper_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~stat_clr) | fire;
  end

  ptp_phase_acc #(.ACC_W(ACC_W)) i_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (step),
    .addend_i (addend_q),
    .tick_o   (tick)
  );

  ptp_prescaler #(.W(DATA_W)) i_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .div_i    (presc_q),
    .outclk_o (outclk_o)
  );

  for (genvar i = 0; i < NUM_FIPER; i++) begin : g_fiper
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                fiper_q[i] <= '0;
      else if (hit(A_FIPER0 + i)) fiper_q[i] <= wr_data_i;
    end

    ptp_fiper #(.W(DATA_W)) i_fiper (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .clr_i      (tod_load),
      .period_i   (nomper_q),
      .interval_i (fiper_q[i]),
      .width_i    (presc_q),
      .fire_o     (fire[i]),
      .pulse_o    (pulse_o[i])
    );
  end

  assign tod_o = tod_q;
  assign irq_o = flag_q & imask_q;
endmodule

// File: rtl/ptp_tod_core_chk.sv
module ptp_tod_core_chk #(
  parameter int DATA_W    = 32,
  parameter int TOD_W     = 64,
  parameter int NUM_FIPER = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 tod_load,
  input logic [TOD_W-1:0]     tod,
  input logic [DATA_W-1:0]    nomper,
  input logic [NUM_FIPER-1:0] flag,
  input logic [NUM_FIPER-1:0] stat_clr,
  input logic [NUM_FIPER-1:0] fire,
  input logic [NUM_FIPER-1:0] pulse
);
  // R2
  tod_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tod_load && tick) |=> (tod == $past(tod) + TOD_W'($past(nomper))));

  // R5
  tod_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tod_load && !tick) |=> $stable(tod));

  // R6
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tod_load |=> (pulse == '0));

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flag) & ~$past(stat_clr)) & ~flag) == '0));

  for (genvar i = 0; i < NUM_FIPER; i++) begin : g_rise
    // R8
    pulse_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse[i]) |-> $past(fire[i]));
  end
endmodule

bind ptp_tod_core ptp_tod_core_chk #(
  .DATA_W    (DATA_W),
  .TOD_W     (TOD_W),
  .NUM_FIPER (NUM_FIPER)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .tod_load (tod_load),
  .tod      (tod_q),
  .nomper   (nomper_q),
  .flag     (flag_q),
  .stat_clr (stat_clr),
  .fire     (fire),
  .pulse    (pulse_o)
);

// File: tb/test_ptp_tod_core.sv
module test_ptp_tod_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ref_tick = '0;
  logic [3:0]  ref_mask = 4'b0010;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] tod;
  logic        outclk;
  logic [1:0]  pulse;
  logic [1:0]  irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  ptp_tod_core i_ptp_tod_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_tick_i (ref_tick),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .tod_o      (tod),
    .outclk_o   (outclk),
    .pulse_o    (pulse),
    .irq_o      (irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic steps(input int n);
    @(negedge clk);
    ref_tick = ref_mask;
    repeat (n) @(negedge clk);
    ref_tick = '0;
  endtask

  task automatic load_tod(input logic [63:0] v);
    wr(4, v[31:0]);
    wr(5, v[63:32]);
  endtask

  task automatic t_reset();
    chk("R1 tod", tod, 64'd0);
    chk("R1 pulse/irq", {62'd0, pulse | irq}, 64'd0);
    // counting disabled at reset
    steps(10);
    chk("R1 disabled", tod, 64'd0);
  endtask

  task automatic t_addend_residue();
    // default select is source 1; only enable is written
    wr(0, 32'd1);
    wr(1, 32'h8000_0000);
    wr(2, 32'd10);
    steps(1);
    chk("R3 no tick yet", tod, 64'd0);
    wr(1, 32'h4000_0000);
    steps(2);
    chk("R3 residue kept", tod, 64'd10);
  endtask

  task automatic t_rate();
    logic [63:0] t0;
    wr(1, 32'h8000_0000);
    t0 = tod;
    steps(20);
    chk("R2 half addend", tod - t0, 64'd100);
    wr(1, 32'h4000_0000);
    t0 = tod;
    steps(40);
    chk("R2 quarter addend", tod - t0, 64'd100);
    wr(1, 32'h8000_0000);
  endtask

  task automatic t_clksel();
    logic [63:0] t0;
    wr(10, 32'd2);
    t0 = tod;
    ref_mask = 4'b1011;
    steps(20);
    chk("R4 unselected ignored", tod, t0);
    ref_mask = 4'b0100;
    steps(20);
    chk("R4 transmit source", tod - t0, 64'd100);
    wr(10, 32'd1);
    ref_mask = 4'b0010;
  endtask

  task automatic t_enable();
    logic [63:0] t0;
    wr(0, 32'd0);
    t0 = tod;
    steps(20);
    chk("R5 disabled hold", tod, t0);
    wr(0, 32'd1);
  endtask

  task automatic t_load_wrap();
    load_tod(64'hFFFF_FFFF_FFFF_FFEC);
    chk("R6 load value", tod, 64'hFFFF_FFFF_FFFF_FFEC);
    steps(6);
    chk("R7 wrap", tod, 64'd10);
  endtask

  task automatic t_fiper();
    logic [1:0]  prev;
    logic [63:0] r0 [2];
    logic [63:0] r1 [2];
    int n0 = 0, n1 = 0, wid = 0, width_done = 0;
    wr(3, 32'd2);
    wr(6, 32'd30);
    wr(7, 32'd50);
    load_tod(64'd0);
    chk("R6 pulses low after load", {62'd0, pulse}, 64'd0);
    prev = pulse;
    @(negedge clk);
    ref_tick = ref_mask;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (pulse[0] && !prev[0] && n0 < 2) begin r0[n0] = tod; n0++; end
      if (pulse[1] && !prev[1] && n1 < 2) begin r1[n1] = tod; n1++; end
      if (!width_done) begin
        if (pulse[0]) wid++;
        else if (prev[0]) width_done = 1;
      end
      prev = pulse;
    end
    ref_tick = '0;
    chk("R6 first pulse after load", r0[0], 64'd40);
    chk("R8 interval gen0", r0[1] - r0[0], 64'd40);
    chk("R8 first gen1", r1[0], 64'd60);
    chk("R8 interval gen1", r1[1] - r1[0], 64'd60);
    chk("R9 width cycles", 64'(wid), 64'd4);
  endtask

  task automatic t_outclk();
    logic prev;
    int run = 0, hi = 0, lo = 0, seen_edge = 0;
    wr(3, 32'd6);
    prev = outclk;
    @(negedge clk);
    ref_tick = ref_mask;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (outclk != prev) begin
        if (seen_edge) begin
          if (prev && hi == 0) hi = run;
          if (!prev && lo == 0) lo = run;
        end
        seen_edge = 1;
        run = 1;
      end else run++;
      prev = outclk;
    end
    ref_tick = '0;
    chk("R10 high run", 64'(hi), 64'd6);
    chk("R10 low run", 64'(lo), 64'd6);
  endtask

  task automatic t_irq();
    chk("R12 masked off", {62'd0, irq}, 64'd0);
    wr(9, 32'd3);
    chk("R12 mask on", {62'd0, irq}, 64'd3);
    wr(8, 32'd0);
    chk("R11 write zero keeps", {62'd0, irq}, 64'd3);
    wr(8, 32'd1);
    chk("R11 clear gen0", {62'd0, irq}, 64'd2);
    wr(8, 32'd2);
    chk("R11 clear gen1", {62'd0, irq}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addend_residue();
    t_rate();
    t_clksel();
    t_enable();
    t_load_wrap();
    t_fiper();
    t_outclk();
    t_irq();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule